// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

The block passes an 18-bit word between two ports, A and B, in either direction. Each direction owns one word of storage and a set of four controls: an active-low output enable, a latch enable, a data strobe and an active-low strobe enable. While latch enable is high the direction is transparent, so the destination output follows the source port in the same cycle. While latch enable is low the direction keeps its stored word. It reloads the word only on an enabled rising edge of its strobe.

All logic runs on one system clock. The strobe is a sampled level, and an edge is seen when a cycle samples it high after a cycle that sampled it low. Each port is modelled at the pad boundary. The block sees the value on the pin and a per-bit mask that says whether something outside drives that bit. It produces an output word and an output enable for the pad driver. A keeper on each port holds every undriven bit at the last level that was on the pin.

Top module: `tcvr_universal`

## Requirements
- R1: While `ab_le` is 1, `b_o` equals the effective A level in the same cycle, with no clock delay.
- R2: While `ab_le` is 0 and no enabled rising strobe edge occurs, the A-to-B storage and `b_o` stay unchanged.
- R3: With `ab_le` at 0 and `ab_clken_n` at 0, the first cycle that samples `ab_clk` high after a cycle that sampled it low loads the effective A level. The loaded word appears on `b_o` one cycle later.
- R4: While `ab_clken_n` is 1, rising edges of `ab_clk` are ignored and the stored word is kept.
- R5: Latch enable has priority over the strobe. An edge while `ab_le` is 1 does no more than transparency does.
- R6: `b_oe` is the inverse of `ab_oe_n` and `a_oe` is the inverse of `ba_oe_n`. Both are 0 while `rst` is 1.
- R7: The B-to-A direction follows R1 to R5, using `ba_le`, `ba_clk` and `ba_clken_n`, with B as source and `a_o` as destination.
- R8: A bit whose `*_drv` bit is 0 reads as the last level on that pin: either the last externally driven value, or the block's own output while it drove the pin.
- R9: Reset clears both stored words to zero. A strobe already high when reset is released does not count as an edge.
- R10: With both output enables active, each port carries its own direction's output. A direction whose source port is driven by the block sees that port's held level from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 18 | Level sensed on the A pins |
| a_drv | input | 18 | Per-bit flag: A pin driven from outside |
| a_o | output | 18 | Word for the A pad drivers (B-to-A path) |
| a_oe | output | 1 | Enable for the A pad drivers |
| b_i | input | 18 | Level sensed on the B pins |
| b_drv | input | 18 | Per-bit flag: B pin driven from outside |
| b_o | output | 18 | Word for the B pad drivers (A-to-B path) |
| b_oe | output | 1 | Enable for the B pad drivers |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B strobe, sampled |
| ab_clken_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A strobe, sampled |
| ba_clken_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The properties assume that nothing outside drives a pin while the block drives it. A drive flag raised during the block's own drive would make the held level ambiguous. They also assume that reset is held for at least two cycles, so that the past values they compare against are the cleared state. The stimulus task clears the drive mask of any port whose facing output enable is active before each cycle, and the bench holds reset for four cycles at start-up.

// File: rtl/tcvr_pkg.sv
`timescale 1ns/1ps
package tcvr_pkg;

    localparam int unsigned TCVR_DEFAULT_W = 18;
    localparam int unsigned TCVR_PORTS     = 2;

    // control bundle for one direction
    typedef struct packed {
        logic oe_n;
        logic le;
        logic strobe;
        logic strobe_en_n;
    } dir_ctrl_t;

    typedef enum logic [1:0] {
        PATH_HOLD    = 2'd0,
        PATH_FOLLOW  = 2'd1,
        PATH_CAPTURE = 2'd2
    } path_mode_e;

    // latch enable wins over an enabled strobe edge
    function automatic path_mode_e pick_mode(input logic le, input logic fire);
        if (le)   return PATH_FOLLOW;
        if (fire) return PATH_CAPTURE;
        return PATH_HOLD;
    endfunction

endpackage

// File: rtl/tcvr_edge_gate.sv
`timescale 1ns/1ps
module tcvr_edge_gate (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic gate_n,
    output logic fire
);
    logic strobe_q;

    // reset arms the detector high: a strobe high at release is no edge
    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b1;
        else     strobe_q <= strobe;
    end

    assign fire = strobe & ~strobe_q & ~gate_n;
endmodule

// File: rtl/tcvr_bus_hold.sv
`timescale 1ns/1ps
module tcvr_bus_hold #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] pin_drv,
    input  logic         self_oe,
    input  logic [W-1:0] self_val,
    output logic [W-1:0] level
);
    logic [W-1:0] keep_q;
    logic [W-1:0] ext;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign ext[i] = pin_drv[i] ? pin_i[i] : keep_q[i];
    end

    // while the block drives the pin, the path reads last cycle's pin level
    assign level = self_oe ? keep_q : ext;

    always_ff @(posedge clk) begin
        if (rst)          keep_q <= '0;
        else if (self_oe) keep_q <= self_val;
        else              keep_q <= ext;
    end
endmodule

// File: rtl/tcvr_dir_path.sv
`timescale 1ns/1ps
module tcvr_dir_path
    import tcvr_pkg::*;
#(
    parameter int unsigned W = TCVR_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic         dst_oe
);
    logic       fire;
    path_mode_e mode;
    logic [W-1:0] held_q;

    tcvr_edge_gate u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctrl.strobe),
        .gate_n (ctrl.strobe_en_n),
        .fire   (fire)
    );

    always_comb mode = pick_mode(ctrl.le, fire);

    always_ff @(posedge clk) begin
        if (rst)                    held_q <= '0;
        else if (mode != PATH_HOLD) held_q <= src;
    end

    assign dst    = (mode == PATH_FOLLOW) ? src : held_q;
    assign dst_oe = ~ctrl.oe_n & ~rst;
endmodule

// File: rtl/tcvr_universal.sv
`timescale 1ns/1ps
module tcvr_universal
    import tcvr_pkg::*;
#(
    parameter int unsigned W = TCVR_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] a_drv,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] b_drv,
    output logic [W-1:0] b_o,
    output logic         b_oe,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_clken_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_clken_n
);
    localparam int unsigned NP = TCVR_PORTS;

    // index p: port p is the source of path p; path p drives port NP-1-p
    dir_ctrl_t    ctrl    [NP];
    logic [W-1:0] pin_i   [NP];
    logic [W-1:0] pin_drv [NP];
    logic [W-1:0] level   [NP];
    logic [W-1:0] dst     [NP];
    logic         dst_oe  [NP];

    assign ctrl[0] = '{oe_n: ab_oe_n, le: ab_le, strobe: ab_clk, strobe_en_n: ab_clken_n};
    assign ctrl[1] = '{oe_n: ba_oe_n, le: ba_le, strobe: ba_clk, strobe_en_n: ba_clken_n};

    assign pin_i[0]   = a_i;
    assign pin_i[1]   = b_i;
    assign pin_drv[0] = a_drv;
    assign pin_drv[1] = b_drv;

    for (genvar p = 0; p < NP; p++) begin : g_dir
        tcvr_bus_hold #(.W(W)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .pin_i    (pin_i[p]),
            .pin_drv  (pin_drv[p]),
            .self_oe  (dst_oe[NP-1-p]),
            .self_val (dst[NP-1-p]),
            .level    (level[p])
        );

        tcvr_dir_path #(.W(W)) u_path (
            .clk    (clk),
            .rst    (rst),
            .ctrl   (ctrl[p]),
            .src    (level[p]),
            .dst    (dst[p]),
            .dst_oe (dst_oe[p])
        );
    end

    assign b_o  = dst[0];
    assign b_oe = dst_oe[0];
    assign a_o  = dst[1];
    assign a_oe = dst_oe[1];
endmodule

// File: rtl/tcvr_universal_checker.sv
`timescale 1ns/1ps
module tcvr_universal_checker #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_i,
    input logic [W-1:0] a_drv,
    input logic [W-1:0] a_o,
    input logic         a_oe,
    input logic [W-1:0] b_i,
    input logic [W-1:0] b_drv,
    input logic [W-1:0] b_o,
    input logic         b_oe,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_clken_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_clk,
    input logic         ba_clken_n
);
    assert_follow_ab_R1: assert property (@(posedge clk) disable iff (rst)
        (ab_le && (a_drv == '1) && !a_oe) |-> (b_o == a_i));

    assert_hold_ab_R2: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !$past(ab_le) && !$past(ab_clk)) |-> (b_o == $past(b_o)));

    assert_gate_ab_R4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !$past(ab_le) && $past(ab_clken_n)) |-> (b_o == $past(b_o)));

    assert_oe_R6: assert property (@(posedge clk) disable iff (rst)
        (b_oe == !ab_oe_n) && (a_oe == !ba_oe_n));

    assert_oe_reset_R6: assert property (@(posedge clk)
        rst |-> (!a_oe && !b_oe));

    assert_follow_ba_R7: assert property (@(posedge clk) disable iff (rst)
        (ba_le && (b_drv == '1) && !b_oe) |-> (a_o == b_i));

    assert_keeper_R8: assert property (@(posedge clk) disable iff (rst)
        (ab_le && $past(ab_le) && !a_oe && !$past(a_oe)
         && (a_drv == '0) && ($past(a_drv) == '0)) |-> (b_o == $past(b_o)));
endmodule

bind tcvr_universal tcvr_universal_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst),
    .a_i(a_i), .a_drv(a_drv), .a_o(a_o), .a_oe(a_oe),
    .b_i(b_i), .b_drv(b_drv), .b_o(b_o), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_clken_n(ab_clken_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_clken_n(ba_clken_n)
);

// File: tb/tcvr_universal_bench.sv
`timescale 1ns/1ps
module tcvr_universal_bench;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // index 0 = A side / A-to-B path, 1 = B side / B-to-A path
    logic [W-1:0] pin [2];
    logic [W-1:0] drv [2];
    logic oe_n [2];
    logic le   [2];
    logic stb  [2];
    logic sen_n[2];

    logic [W-1:0] a_o, b_o;
    logic         a_oe, b_oe;

    tcvr_universal #(.W(W)) u_tcvr_universal (
        .clk(clk), .rst(rst),
        .a_i(pin[0]), .a_drv(drv[0]), .a_o(a_o), .a_oe(a_oe),
        .b_i(pin[1]), .b_drv(drv[1]), .b_o(b_o), .b_oe(b_oe),
        .ab_oe_n(oe_n[0]), .ab_le(le[0]), .ab_clk(stb[0]), .ab_clken_n(sen_n[0]),
        .ba_oe_n(oe_n[1]), .ba_le(le[1]), .ba_clk(stb[1]), .ba_clken_n(sen_n[1])
    );

    // reference state
    logic [W-1:0] m_store [2];
    logic [W-1:0] m_keep  [2];
    logic         m_prev  [2];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic port_oe(int q);
        return !rst && !oe_n[1-q];
    endfunction

    function automatic logic [W-1:0] seen(int q);
        if (port_oe(q)) return m_keep[q];
        return (drv[q] & pin[q]) | (~drv[q] & m_keep[q]);
    endfunction

    function automatic logic [W-1:0] path_out(int p);
        return le[p] ? seen(p) : m_store[p];
    endfunction

    task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // one cycle: inputs are set, sample mid-cycle, then advance the model at the edge
    task automatic cyc(string req);
        for (int q = 0; q < 2; q++) if (!oe_n[1-q]) drv[q] = '0;
        #1;
        cmp(req, "b_o",  b_o,  path_out(0));
        cmp(req, "a_o",  a_o,  path_out(1));
        cmp(req, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, port_oe(1)});
        cmp(req, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, port_oe(0)});
        @(posedge clk);
        begin
            logic [W-1:0] nst [2];
            logic [W-1:0] nkp [2];
            logic         npv [2];
            for (int p = 0; p < 2; p++) begin
                logic fire;
                fire   = stb[p] && !m_prev[p] && !sen_n[p];
                nst[p] = (le[p] || fire) ? seen(p) : m_store[p];
                npv[p] = stb[p];
                nkp[p] = port_oe(p) ? path_out(1-p)
                                    : ((drv[p] & pin[p]) | (~drv[p] & m_keep[p]));
            end
            for (int p = 0; p < 2; p++) begin
                m_store[p] = rst ? '0 : nst[p];
                m_keep[p]  = rst ? '0 : nkp[p];
                m_prev[p]  = rst ? 1'b1 : npv[p];
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom());
    endfunction

    task automatic idle_all();
        for (int p = 0; p < 2; p++) begin
            oe_n[p] = 1'b1; le[p] = 1'b0; stb[p] = 1'b0; sen_n[p] = 1'b0;
            pin[p] = '0; drv[p] = '1;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_all();
        for (int p = 0; p < 2; p++) begin
            m_store[p] = '0; m_keep[p] = '0; m_prev[p] = 1'b1;
        end
        // R9 / R6: reset with strobe high and output enables requested
        stb[0] = 1'b1; stb[1] = 1'b1; oe_n[0] = 1'b0; oe_n[1] = 1'b0;
        pin[0] = rnd(); pin[1] = rnd();
        @(negedge clk);
        for (int i = 0; i < 4; i++) cyc("R9");
        rst = 1'b0;
        oe_n[0] = 1'b1; oe_n[1] = 1'b1;
        // strobe still high at release: no capture, outputs read zero
        for (int i = 0; i < 3; i++) begin pin[0] = rnd(); pin[1] = rnd(); cyc("R9"); end
        cmp("R9", "b_o after reset", b_o, '0);

        // R1 transparency A to B
        idle_all(); oe_n[0] = 1'b0; le[0] = 1'b1;
        for (int i = 0; i < 20; i++) begin pin[0] = rnd(); cyc("R1"); end

        // R3 capture on enabled rising strobe
        le[0] = 1'b0;
        for (int i = 0; i < 40; i++) begin pin[0] = rnd(); stb[0] = ($urandom() % 2) == 0; cyc("R3"); end
        stb[0] = 1'b0; pin[0] = 18'h2A5C3; cyc("R3");
        stb[0] = 1'b1; cyc("R3");
        pin[0] = 18'h00F0F; cyc("R3");
        cmp("R3", "b_o captured word", b_o, 18'h2A5C3);

        // R2 hold with steady strobe
        for (int i = 0; i < 15; i++) begin pin[0] = rnd(); cyc("R2"); end
        stb[0] = 1'b0;
        for (int i = 0; i < 15; i++) begin pin[0] = rnd(); cyc("R2"); end
        cmp("R2", "b_o held", b_o, 18'h2A5C3);

        // R4 disabled strobe edges ignored
        sen_n[0] = 1'b1;
        for (int i = 0; i < 30; i++) begin pin[0] = rnd(); stb[0] = ~stb[0]; cyc("R4"); end
        cmp("R4", "b_o unchanged", b_o, 18'h2A5C3);
        sen_n[0] = 1'b0;

        // R5 latch priority with strobe toggling
        le[0] = 1'b1;
        for (int i = 0; i < 30; i++) begin pin[0] = rnd(); stb[0] = ($urandom() % 2) == 0; cyc("R5"); end
        le[0] = 1'b0; stb[0] = 1'b1;
        for (int i = 0; i < 4; i++) begin pin[0] = rnd(); cyc("R5"); end

        // R7 the B-to-A direction under all its modes
        idle_all(); oe_n[1] = 1'b0;
        for (int i = 0; i < 80; i++) begin
            pin[1] = rnd(); le[1] = ($urandom() % 3) == 0;
            stb[1] = ($urandom() % 2) == 0; sen_n[1] = ($urandom() % 4) == 0;
            cyc("R7");
        end

        // R8 keeper with partial drive masks
        idle_all(); oe_n[0] = 1'b0; oe_n[1] = 1'b0; le[0] = 1'b1; le[1] = 1'b1;
        oe_n[0] = 1'b1; oe_n[1] = 1'b1;
        for (int i = 0; i < 60; i++) begin
            pin[0] = rnd(); pin[1] = rnd();
            drv[0] = rnd(); drv[1] = (i % 5 == 0) ? '0 : rnd();
            le[0] = ($urandom() % 2) == 0; le[1] = ($urandom() % 2) == 0;
            oe_n[0] = ($urandom() % 2) == 0; oe_n[1] = ($urandom() % 2) == 0;
            stb[0] = ($urandom() % 2) == 0; stb[1] = ($urandom() % 2) == 0;
            cyc("R8");
        end

        // R10 both directions driving at once
        idle_all(); oe_n[0] = 1'b0; oe_n[1] = 1'b0;
        for (int i = 0; i < 50; i++) begin
            le[0] = ($urandom() % 2) == 0; le[1] = ($urandom() % 2) == 0;
            stb[0] = ($urandom() % 2) == 0; stb[1] = ($urandom() % 2) == 0;
            sen_n[0] = ($urandom() % 3) == 0; sen_n[1] = ($urandom() % 3) == 0;
            pin[0] = rnd(); pin[1] = rnd();
            cyc("R10");
        end

        // R6 output enables toggling, then a mixed run
        idle_all();
        for (int i = 0; i < 300; i++) begin
            oe_n[0] = ($urandom() % 2) == 0; oe_n[1] = ($urandom() % 2) == 0;
            le[0] = ($urandom() % 3) == 0; le[1] = ($urandom() % 3) == 0;
            stb[0] = ($urandom() % 2) == 0; stb[1] = ($urandom() % 2) == 0;
            sen_n[0] = ($urandom() % 4) == 0; sen_n[1] = ($urandom() % 4) == 0;
            pin[0] = rnd(); pin[1] = rnd(); drv[0] = rnd(); drv[1] = rnd();
            cyc("R6");
        end

        // R9 reset mid-run clears stored words
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R9");
        rst = 1'b0; le[0] = 1'b0; le[1] = 1'b0; sen_n[0] = 1'b1; sen_n[1] = 1'b1;
        cyc("R9");
        cmp("R9", "b_o cleared", b_o, '0);
        cmp("R9", "a_o cleared", a_o, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule